// File: doc/BRIEF.md
# TFT Panel Timing Generator

This block runs on the pixel clock and drives the raster of a 640x480 TFT panel. It produces the horizontal sync, the vertical sync and data-enable. It also pulls 32-bit words from an upstream display FIFO and sends them to the panel as 16-bit RGB565 pixels. Each word carries two pixels, so the FIFO is read once for every two pixel clocks. The first pixel of a pair comes from bits 31:16 and the second from bits 15:0.

Two counters track the position. A horizontal counter counts pixel clocks within a line. A vertical counter counts whole lines within a frame. Both count from a zero origin that marks the start of the front porch. The blanking phases come first and the visible region ends each line and each frame. Every width is a parameter, so a simulation can run a shrunken raster.

The FIFO is assumed to present its word one clock after a read request. For this reason the request leads data-enable by one clock. A `go` input runs the raster, and clearing it parks the raster at its origin.

Top module: `tft_timing_gen`

## Requirements
- R1: With `go_i` high, each line lasts H_FRONT+H_SYNC+H_BACK+H_ACTIVE clocks, counted from the horizontal origin. The line is H_FRONT clocks of front porch, then H_SYNC clocks with `hsync_n_o` low, then H_BACK clocks of back porch, then H_ACTIVE clocks of visible region. `hsync_n_o` is high in every other clock of the line.
- R2: The vertical position advances by one only on the last clock of a line. A frame is V_FRONT lines of front porch, then V_SYNC lines with `vsync_n_o` low, then V_BACK lines of back porch, then V_ACTIVE visible lines.
- R3: `de_o` is high exactly when both the horizontal and the vertical position are in their visible regions.
- R4: On each visible line, `fifo_rd_o` is high in the clock just before `de_o` rises.
- R5: Inside the visible region, `fifo_rd_o` is a one-clock pulse on the 2nd, 4th, ... visible clock, up to and including the clock three before `de_o` falls. This gives H_ACTIVE/2 requests per visible line. No request is made on non-visible lines, and none in the last two clocks of the visible region.
- R6: On the visible clock with even index 2k of a line, `pix_o[15:0]` equals bits 31:16 of the word returned for the line's k-th request. On index 2k+1 it equals bits 15:0 of the same word. `pix_o[17:16]` is always zero.
- R7: `pix_o` is all zero whenever `de_o` is low.
- R8: While `rst_n` is low, and from the first clock after `go_i` is seen low, both counters are at the origin. In that state `de_o` and `fifo_rd_o` are low, and `hsync_n_o`, `vsync_n_o` are high. After `go_i` rises, the raster resumes from the origin, so the first `de_o` comes V_BLANK*H_TOTAL+H_BLANK clocks later. Here H_BLANK is the sum of the three horizontal blanking widths, V_BLANK the sum of the three vertical ones, and H_TOTAL is H_BLANK+H_ACTIVE.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Pixel clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| go_i | input | 1 | Run enable; low parks the raster at its origin |
| fifo_q_i | input | 32 | Word from the display FIFO, two pixels, high half first |
| fifo_rd_o | output | 1 | FIFO read request, one-clock pulses |
| hsync_n_o | output | 1 | Horizontal sync, active low |
| vsync_n_o | output | 1 | Vertical sync, active low |
| de_o | output | 1 | Data enable, active high |
| pix_o | output | 18 | Panel data: RGB565 in bits 15:0, bits 17:16 zero |

## Verification
The assertions take three things for granted. First, `go_i` changes only between clock edges. Second, H_ACTIVE is even and the horizontal blanking is at least one clock. Third, the FIFO returns the requested word on the clock after a pulse of `fifo_rd_o`; the assertions do not check data values. The bench stays within these assumptions. It toggles `go_i` and `rst_n` only at falling edges, uses a reduced raster with an even visible width, and models the FIFO as a register loaded with a numbered word on each request. The assertion on a falling `de_o` is qualified by `go_i`, because an early stop legitimately cuts a read window short.

// File: rtl/tft_tim_pkg.sv
package tft_tim_pkg;

    // Phase of one raster axis, in the order the counter walks through it
    typedef enum logic [1:0] {
        PH_FRONT  = 2'd0,
        PH_SYNC   = 2'd1,
        PH_BACK   = 2'd2,
        PH_ACTIVE = 2'd3
    } tft_phase_e;

    localparam int unsigned PIX_W   = 16;
    localparam int unsigned WORD_W  = 2 * PIX_W;
    localparam int unsigned PANEL_W = 18;

endpackage

// File: rtl/tft_axis_ctr.sv
module tft_axis_ctr
    import tft_tim_pkg::*;
#(
    parameter int unsigned FRONT  = 16,
    parameter int unsigned SYNC   = 96,
    parameter int unsigned BACK   = 144,
    parameter int unsigned ACTIVE = 640,
    localparam int unsigned TOTAL = FRONT + SYNC + BACK + ACTIVE,
    localparam int unsigned CW    = $clog2(TOTAL)
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          run_i,
    input  logic          step_i,
    output logic [CW-1:0] cnt_o,
    output logic          last_o,
    output tft_phase_e    phase_o
);

    localparam logic [CW-1:0] L_SYNC = CW'(FRONT);
    localparam logic [CW-1:0] L_BACK = CW'(FRONT + SYNC);
    localparam logic [CW-1:0] L_ACT  = CW'(TOTAL - ACTIVE);
    localparam logic [CW-1:0] L_LAST = CW'(TOTAL - 1);

    typedef struct packed {
        logic [CW-1:0] cnt;
    } ctr_state_t;

    ctr_state_t state_d, state_q;

    always_comb begin
        state_d = state_q;
        if (!run_i) begin
            state_d.cnt = '0;
        end else if (step_i) begin
            state_d.cnt = (state_q.cnt == L_LAST) ? '0 : state_q.cnt + 1'b1;
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            state_q <= '0;
        end else begin
            state_q <= state_d;
        end
    end

    assign cnt_o  = state_q.cnt;
    assign last_o = (state_q.cnt == L_LAST);

    always_comb begin
        if (state_q.cnt < L_SYNC) begin
            phase_o = PH_FRONT;
        end else if (state_q.cnt < L_BACK) begin
            phase_o = PH_SYNC;
        end else if (state_q.cnt < L_ACT) begin
            phase_o = PH_BACK;
        end else begin
            phase_o = PH_ACTIVE;
        end
    end

    AST_CNT_BOUND: assert property (@(posedge clk) disable iff (!rst_n)
        state_q.cnt <= L_LAST);                                            // R1
    AST_CNT_HALT: assert property (@(posedge clk) disable iff (!rst_n)
        !run_i |=> (state_q.cnt == '0));                                   // R8
    AST_CNT_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
        (run_i && !step_i) |=> $stable(state_q.cnt));                      // R2

endmodule

// File: rtl/tft_pix_unpack.sv
module tft_pix_unpack
    import tft_tim_pkg::*;
(
    input  logic              clk,
    input  logic              rst_n,
    input  logic              run_i,
    input  logic              pre_i,
    input  logic              de_i,
    input  logic              tail_i,
    input  logic [WORD_W-1:0] word_i,
    output logic              rd_o,
    output logic [PIX_W-1:0]  pix_o
);

    typedef struct packed {
        logic odd;   // set while the low half of the current word is on the bus
    } pair_state_t;

    pair_state_t state_d, state_q;

    always_comb begin
        state_d     = state_q;
        state_d.odd = (run_i && de_i) ? !state_q.odd : 1'b0;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            state_q <= '0;
        end else begin
            state_q <= state_d;
        end
    end

    // Prefetch one clock ahead of the line, then refill after each low half,
    // stopping before the last word is consumed.
    assign rd_o = pre_i || (de_i && state_q.odd && !tail_i);

    always_comb begin
        if (!de_i) begin
            pix_o = '0;
        end else if (state_q.odd) begin
            pix_o = word_i[PIX_W-1:0];
        end else begin
            pix_o = word_i[WORD_W-1:PIX_W];
        end
    end

    AST_RD_SINGLE: assert property (@(posedge clk) disable iff (!rst_n)
        rd_o |=> !rd_o);                                                   // R5

endmodule

// File: rtl/tft_timing_gen.sv
module tft_timing_gen
    import tft_tim_pkg::*;
#(
    parameter int unsigned H_ACTIVE = 640,
    parameter int unsigned H_FRONT  = 16,
    parameter int unsigned H_SYNC   = 96,
    parameter int unsigned H_BACK   = 144,
    parameter int unsigned V_ACTIVE = 480,
    parameter int unsigned V_FRONT  = 10,
    parameter int unsigned V_SYNC   = 2,
    parameter int unsigned V_BACK   = 35
) (
    input  logic        clk,
    input  logic        rst_n,
    input  logic        go_i,
    input  logic [31:0] fifo_q_i,
    output logic        fifo_rd_o,
    output logic        hsync_n_o,
    output logic        vsync_n_o,
    output logic        de_o,
    output logic [17:0] pix_o
);

    localparam int unsigned H_BLANK = H_FRONT + H_SYNC + H_BACK;
    localparam int unsigned H_TOTAL = H_BLANK + H_ACTIVE;
    localparam int unsigned V_TOTAL = V_FRONT + V_SYNC + V_BACK + V_ACTIVE;
    localparam int unsigned HCW     = $clog2(H_TOTAL);
    localparam int unsigned VCW     = $clog2(V_TOTAL);
    localparam logic [HCW-1:0] H_PRE  = HCW'(H_BLANK - 1);
    localparam logic [HCW-1:0] H_TAIL = HCW'(H_TOTAL - 2);

    logic [HCW-1:0] h_cnt;
    logic [VCW-1:0] v_cnt;
    logic           h_last, v_last;
    tft_phase_e     h_phase, v_phase;
    logic           h_vis, v_vis, line_pre, line_tail;
    logic [PIX_W-1:0] pix16;

    tft_axis_ctr #(
        .FRONT (H_FRONT),
        .SYNC  (H_SYNC),
        .BACK  (H_BACK),
        .ACTIVE(H_ACTIVE)
    ) i_hctr (
        .clk    (clk),
        .rst_n  (rst_n),
        .run_i  (go_i),
        .step_i (1'b1),
        .cnt_o  (h_cnt),
        .last_o (h_last),
        .phase_o(h_phase)
    );

    tft_axis_ctr #(
        .FRONT (V_FRONT),
        .SYNC  (V_SYNC),
        .BACK  (V_BACK),
        .ACTIVE(V_ACTIVE)
    ) i_vctr (
        .clk    (clk),
        .rst_n  (rst_n),
        .run_i  (go_i),
        .step_i (h_last),
        .cnt_o  (v_cnt),
        .last_o (v_last),
        .phase_o(v_phase)
    );

    assign h_vis     = (h_phase == PH_ACTIVE);
    assign v_vis     = (v_phase == PH_ACTIVE);
    assign line_pre  = v_vis && (h_cnt == H_PRE);
    assign line_tail = (h_cnt >= H_TAIL);

    tft_pix_unpack i_unpack (
        .clk   (clk),
        .rst_n (rst_n),
        .run_i (go_i),
        .pre_i (line_pre),
        .de_i  (de_o),
        .tail_i(line_tail),
        .word_i(fifo_q_i),
        .rd_o  (fifo_rd_o),
        .pix_o (pix16)
    );

    assign de_o      = h_vis && v_vis;
    assign hsync_n_o = (h_phase != PH_SYNC);
    assign vsync_n_o = (v_phase != PH_SYNC);
    assign pix_o     = {{(PANEL_W - PIX_W){1'b0}}, pix16};

    AST_DE_NO_SYNC: assert property (@(posedge clk) disable iff (!rst_n)
        de_o |-> (hsync_n_o && vsync_n_o));                                // R3
    AST_RD_LEADS_DE: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(de_o) |-> $past(fifo_rd_o));                                 // R4
    AST_RD_ENDS_EARLY: assert property (@(posedge clk) disable iff (!rst_n)
        ($fell(de_o) && $past(go_i)) |-> !$past(fifo_rd_o));               // R5
    AST_IDLE_ON_STOP: assert property (@(posedge clk) disable iff (!rst_n)
        !go_i |=> (!de_o && hsync_n_o && vsync_n_o && !fifo_rd_o));        // R8
    AST_V_STEP_AT_EOL: assert property (@(posedge clk) disable iff (!rst_n)
        (go_i && !h_last) |=> $stable(v_cnt));                             // R2
    AST_V_WRAP: assert property (@(posedge clk) disable iff (!rst_n)
        (go_i && h_last && v_last) |=> (v_cnt == '0));                     // R2

endmodule

// File: tb/test_tft_timing_gen.sv
`timescale 1ns/1ps
module test_tft_timing_gen;

    localparam int HA = 8, HF = 2, HS = 3, HBP = 3;
    localparam int VA = 4, VF = 1, VS = 2, VBP = 1;
    localparam int HBL = HF + HS + HBP;
    localparam int HT  = HBL + HA;
    localparam int VBL = VF + VS + VBP;
    localparam int VT  = VBL + VA;
    localparam int FRAME = HT * VT;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        go = 1'b0;
    logic [31:0] fifo_q = 32'hDEAD_BEEF;
    logic        fifo_rd, hs_n, vs_n, de;
    logic [17:0] pix;
    int          rd_cnt = 0;
    int          checks = 0;
    int          fails = 0;

    always #10 clk = ~clk;

    tft_timing_gen #(
        .H_ACTIVE(HA), .H_FRONT(HF), .H_SYNC(HS), .H_BACK(HBP),
        .V_ACTIVE(VA), .V_FRONT(VF), .V_SYNC(VS), .V_BACK(VBP)
    ) i_tft_timing_gen (
        .clk(clk), .rst_n(rst_n), .go_i(go), .fifo_q_i(fifo_q),
        .fifo_rd_o(fifo_rd), .hsync_n_o(hs_n), .vsync_n_o(vs_n),
        .de_o(de), .pix_o(pix)
    );

    function automatic logic [31:0] word_of(int k);
        return {16'(16'h1000 + k * 3), 16'(16'h8000 + k * 5)};
    endfunction

    // FIFO model: word appears on the clock after a request
    always @(posedge clk) begin
        if (fifo_rd) begin
            fifo_q <= word_of(rd_cnt);
            rd_cnt <= rd_cnt + 1;
        end
    end

    task automatic chk(bit ok, string req, string what, logic [31:0] act, logic [31:0] exp);
        checks++;
        if (!ok) begin
            fails++;
            $display("FAIL %s %s actual=%h expected=%h", req, what, act, exp);
        end
    endtask

    task automatic chk_idle(string req, string what);
        chk(de == 1'b0,   req, {what, " de"},   32'(de),   32'd0);
        chk(hs_n == 1'b1, req, {what, " hs_n"}, 32'(hs_n), 32'd1);
        chk(vs_n == 1'b1, req, {what, " vs_n"}, 32'(vs_n), 32'd1);
        chk(fifo_rd == 1'b0, req, {what, " rd"}, 32'(fifo_rd), 32'd0);
        chk(pix == 18'd0, req, {what, " pix"},  32'(pix),  32'd0);
    endtask

    // R8: outputs idle while held in reset
    task automatic t_reset_state();
        rst_n = 1'b0;
        go = 1'b1;
        repeat (3) @(negedge clk);
        chk_idle("R8", "in reset");
        go = 1'b0;
        @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        chk_idle("R8", "after reset, go low");
    endtask

    // R1..R7: run nf frames from the origin and compare every clock
    task automatic t_frames(int nf);
        int base;
        go = 1'b0;
        @(negedge clk);
        @(negedge clk);
        base = rd_cnt;
        go = 1'b1;
        #1;
        for (int c = 0; c < nf * FRAME; c++) begin
            int h, v, f, p;
            bit e_de, e_rd, e_hs, e_vs;
            logic [31:0] w;
            logic [17:0] e_pix;
            if (c != 0) begin
                @(negedge clk);
                #1;
            end
            h = c % HT;
            v = (c / HT) % VT;
            f = c / FRAME;
            e_hs = !(h >= HF && h < HF + HS);
            e_vs = !(v >= VF && v < VF + VS);
            e_de = (h >= HBL) && (v >= VBL);
            e_rd = (v >= VBL) && ((h == HBL - 1) ||
                   (h > HBL && h < HT - 2 && ((h - HBL) % 2) == 1));
            e_pix = '0;
            if (e_de) begin
                p = f * VA * HA + (v - VBL) * HA + (h - HBL);
                w = word_of(base + p / 2);
                e_pix = (p % 2 == 0) ? {2'b00, w[31:16]} : {2'b00, w[15:0]};
            end
            chk(hs_n == e_hs, "R1", $sformatf("hsync c=%0d", c), 32'(hs_n), 32'(e_hs));
            chk(vs_n == e_vs, "R2", $sformatf("vsync c=%0d", c), 32'(vs_n), 32'(e_vs));
            chk(de == e_de,   "R3", $sformatf("de c=%0d", c),    32'(de),   32'(e_de));
            if (h == HBL - 1)
                chk(fifo_rd == e_rd, "R4", $sformatf("prefetch c=%0d", c), 32'(fifo_rd), 32'(e_rd));
            else
                chk(fifo_rd == e_rd, "R5", $sformatf("read c=%0d", c), 32'(fifo_rd), 32'(e_rd));
            if (e_de)
                chk(pix == e_pix, "R6", $sformatf("pixel c=%0d", c), 32'(pix), 32'(e_pix));
            else
                chk(pix == 18'd0, "R7", $sformatf("blank pix c=%0d", c), 32'(pix), 32'd0);
        end
        chk(rd_cnt - base == nf * VA * HA / 2, "R5", "reads per run",
            32'(rd_cnt - base), 32'(nf * VA * HA / 2));
    endtask

    // R8: drop go after n clocks of running, outputs idle on the next clock
    task automatic t_stop(int n, string what);
        go = 1'b0;
        @(negedge clk);
        @(negedge clk);
        go = 1'b1;
        repeat (n) @(negedge clk);
        go = 1'b0;
        @(negedge clk);
        #1;
        chk_idle("R8", what);
    endtask

    // R8: reset while running, then first de after the full blanking lead
    task automatic t_reset_restart();
        int first;
        go = 1'b1;
        repeat (45) @(negedge clk);
        rst_n = 1'b0;
        #1;
        chk_idle("R8", "async reset mid-line");
        go = 1'b0;
        @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        go = 1'b1;
        #1;
        first = -1;
        for (int c = 0; c < FRAME && first < 0; c++) begin
            if (c != 0) begin
                @(negedge clk);
                #1;
            end
            if (de) first = c;
        end
        chk(first == VBL * HT + HBL, "R8", "first de after restart",
            32'(first), 32'(VBL * HT + HBL));
    endtask

    initial begin
        #(20 * 200000);
        fails++;
        $display("FAIL watchdog: run did not finish");
        $display("  TB_RESULT checks=%0d failures=%0d", checks, fails);
        $finish;
    end

    initial begin
        t_reset_state();
        t_frames(2);
        t_stop(VBL * HT + HBL + 3, "stop inside visible region");
        t_stop(HT + HF + 1, "stop during both syncs");
        t_frames(1);
        t_reset_restart();
        $display("  TB_RESULT checks=%0d failures=%0d", checks, fails);
        $finish;
    end

endmodule